// File: doc/BRIEF.md
# Accumulator Instruction Sequencer

This block is a small single-accumulator processor core. It walks each instruction through a fixed series of register-transfer steps. The program counter feeds a memory address register. A memory buffer register catches the word read back. That word is then latched into an instruction register. The execute steps reuse the same address and buffer registers to reach the operand. The core drives one single-port synchronous word memory, where read data appears on the clock edge after the read strobe. It also drives a simple device port that carries a 4-bit device number.

The instruction set has five operations: load, store and add against memory, plus device input and device output. Any other opcode does nothing. A `halt` input, sampled only at the first step of a fetch, freezes the core between instructions. The `cyc_state` output exposes the current step, so a test environment can single-step programs.

Top module: `acc_seq`

## Requirements
- R1: An instruction word is 16 bits. Bits [15:12] hold the opcode and bits [11:0] the operand address. For device operations, the device number is the low 4 bits [3:0] of that field.
- R2: Fetch takes 4 cycles. It issues one memory read at the program counter address, and the program counter steps by one. Successive instructions are fetched from consecutive addresses.
- R3: Opcode 0x1 loads the accumulator from the addressed memory word. The whole instruction takes 8 cycles and issues 2 memory reads.
- R4: Opcode 0x5 adds the addressed memory word to the accumulator, and the result wraps modulo 2^16. It takes 8 cycles and issues 2 memory reads.
- R5: Opcode 0x2 writes the accumulator to the addressed memory word and leaves the accumulator unchanged. It takes 7 cycles with exactly one write strobe. The read and write strobes are never high together.
- R6: Opcode 0x3 loads the accumulator from device input data with one `dev_rd` pulse. It takes 6 cycles.
- R7: Opcode 0x7 presents the accumulator on `dev_wdata` with one `dev_wr` pulse. It takes 6 cycles.
- R8: Any other opcode takes 5 cycles and makes no memory or device access beyond its fetch. The accumulator keeps its value.
- R9: Reset, applied at any point, returns the core to step 0 with all strobes low. It clears the accumulator and makes the next fetch come from parameter `START_ADDR`.
- R10: `halt` is looked at only in step 0 (`cyc_state` = 0). While it is high there, the core stays in step 0 and issues no strobes. An instruction already started always finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Hold at the start of fetch |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Memory read strobe; data is expected one cycle later |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| dev_num | output | 4 | Device number |
| dev_rd | output | 1 | Device input strobe |
| dev_rdata | input | 16 | Device input data |
| dev_wr | output | 1 | Device output strobe |
| dev_wdata | output | 16 | Device output data |
| cyc_state | output | 4 | Current micro-step, 0 = start of fetch |

## Verification
The accumulator has no port of its own. After every instruction under test, an output instruction is fetched, so a wrong accumulator value shows on `dev_wdata` within six cycles. A broken program counter or a wrong step sequence shows at once as a wrong fetch address or a wrong number of cycles between returns to step 0. Stray accesses are counted per instruction, so an extra or missing strobe shows up in the same instruction.

// File: rtl/acc_seq.sv
module acc_seq #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int OPW = 4,
  parameter int DEVW = 4,
  parameter logic [AW-1:0] START_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DEVW-1:0] dev_num,
  output logic            dev_rd,
  input  logic [DW-1:0]   dev_rdata,
  output logic            dev_wr,
  output logic [DW-1:0]   dev_wdata,
  output logic [3:0]      cyc_state
);
  localparam logic [AW-1:0] PC_STEP = AW'(1);
  localparam logic [OPW-1:0] OP_LD  = OPW'(4'h1);
  localparam logic [OPW-1:0] OP_ST  = OPW'(4'h2);
  localparam logic [OPW-1:0] OP_IN  = OPW'(4'h3);
  localparam logic [OPW-1:0] OP_ADD = OPW'(4'h5);
  localparam logic [OPW-1:0] OP_OUT = OPW'(4'h7);

  typedef enum logic [3:0] {
    F_MAR = 4'd0, F_RD = 4'd1, F_MBR = 4'd2, F_IR = 4'd3,
    X_MAR = 4'd4, X_RD = 4'd5, X_MBR = 4'd6, X_ACC = 4'd7,
    X_BUF = 4'd8, X_WR = 4'd9, X_DIN = 4'd10, X_DOUT = 4'd11
  } step_t;

  step_t          state;
  logic [AW-1:0]  pc, mar;
  logic [DW-1:0]  mbr, ir, acc;
  logic [OPW-1:0] opcode;

  assign opcode    = ir[DW-1 -: OPW];
  assign mem_addr  = mar;
  assign mem_rd    = (state == F_RD) || (state == X_RD);
  assign mem_wr    = (state == X_WR);
  assign mem_wdata = mbr;
  assign dev_num   = mar[DEVW-1:0];
  assign dev_rd    = (state == X_DIN);
  assign dev_wr    = (state == X_DOUT);
  assign dev_wdata = acc;
  assign cyc_state = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= F_MAR;
      pc    <= START_ADDR;
      mar   <= '0;
      mbr   <= '0;
      ir    <= '0;
      acc   <= '0;
    end else begin
      case (state)
        F_MAR: begin
          mar <= pc;
          if (!halt) state <= F_RD;
        end
        F_RD: begin
          pc    <= pc + PC_STEP;
          state <= F_MBR;
        end
        F_MBR: begin
          mbr   <= mem_rdata;
          state <= F_IR;
        end
        F_IR: begin
          ir    <= mbr;
          state <= X_MAR;
        end
        X_MAR: begin
          mar <= ir[AW-1:0];
          case (opcode)
            OP_LD, OP_ADD: state <= X_RD;
            OP_ST:         state <= X_BUF;
            OP_IN:         state <= X_DIN;
            OP_OUT:        state <= X_DOUT;
            default:       state <= F_MAR;
          endcase
        end
        X_RD:  state <= X_MBR;
        X_MBR: begin
          mbr   <= mem_rdata;
          state <= X_ACC;
        end
        X_ACC: begin
          acc   <= (opcode == OP_ADD) ? acc + mbr : mbr;
          state <= F_MAR;
        end
        X_BUF: begin
          mbr   <= acc;
          state <= X_WR;
        end
        X_WR:  state <= F_MAR;
        X_DIN: begin
          acc   <= dev_rdata;
          state <= F_MAR;
        end
        X_DOUT: state <= F_MAR;
        default: state <= F_MAR;
      endcase
    end
  end

  assert_no_rd_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == F_RD) |=> (pc == $past(pc) + PC_STEP));

  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != F_RD) |=> $stable(pc));

  assert_ir_from_mbr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == F_IR) |=> (ir == $past(mbr)));

  assert_store_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata == acc));

  assert_acc_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != X_ACC && state != X_DIN) |=> $stable(acc));

  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == F_MAR && halt) |=> (state == F_MAR && !mem_rd && !mem_wr && !dev_rd && !dev_wr));
endmodule

// File: tb/sim_acc_seq.sv
module sim_acc_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] START = 12'h010;
  localparam logic [15:0] OUT5 = 16'h7005;
  localparam int NV = 9;
  // {instruction, accumulator expected afterwards, cycles expected}
  localparam logic [39:0] VEC [NV] = '{
    {16'h1080, 16'h1234, 8'd8},
    {16'h5081, 16'h2143, 8'd8},
    {16'h2090, 16'h2143, 8'd7},
    {16'h1082, 16'hFFFF, 8'd8},
    {16'h5083, 16'h0000, 8'd8},
    {16'h3006, 16'hA006, 8'd6},
    {16'h0123, 16'hA006, 8'd5},
    {16'hF000, 16'hA006, 8'd5},
    {16'h5082, 16'hA005, 8'd8}
  };

  logic clk = 0, rst_n = 0, halt = 1;
  logic [11:0] mem_addr;
  logic mem_rd, mem_wr, dev_rd, dev_wr;
  logic [15:0] mem_wdata, mem_rdata, dev_wdata, dev_rdata;
  logic [3:0] dev_num, cyc_state;
  logic [15:0] mem [256];
  int rd_n, wr_n, din_n, dout_n;
  logic [15:0] last_out;
  logic [3:0] last_dev;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_seq #(.START_ADDR(START)) u0 (
    .clk(clk), .rst_n(rst_n), .halt(halt),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_num(dev_num), .dev_rd(dev_rd), .dev_rdata(dev_rdata),
    .dev_wr(dev_wr), .dev_wdata(dev_wdata), .cyc_state(cyc_state));

  assign dev_rdata = 16'hA000 | {12'h000, dev_num};

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) rd_n <= rd_n + 1;
    if (mem_wr) wr_n <= wr_n + 1;
    if (dev_rd) din_n <= din_n + 1;
    if (dev_wr) begin
      dout_n <= dout_n + 1;
      last_out <= dev_wdata;
      last_dev <= dev_num;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(output int cyc, output logic [11:0] faddr,
                      output int drd, output int dwr, output int ddin, output int ddout);
    int r0, w0, i0, o0;
    @(negedge clk);
    r0 = rd_n; w0 = wr_n; i0 = din_n; o0 = dout_n;
    halt = 0;
    @(posedge clk);
    cyc = 1;
    @(negedge clk);
    halt = 1;  // raised mid-instruction: the instruction must still finish (R10)
    faddr = mem_addr;
    while (cyc_state != 4'd0 && cyc < 40) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    drd = rd_n - r0; dwr = wr_n - w0; ddin = din_n - i0; ddout = dout_n - o0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cyc, drd, dwr, ddin, ddout;
    logic [11:0] fa, pc_exp;
    logic [3:0] op;
    int exp_rd;
    rd_n = 0; wr_n = 0; din_n = 0; dout_n = 0; last_out = '0; last_dev = '0;
    mem_rdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h80] = 16'h1234; mem[8'h81] = 16'h0F0F;
    mem[8'h82] = 16'hFFFF; mem[8'h83] = 16'h0001;
    mem[START[7:0]] = OUT5;
    for (int i = 0; i < NV; i++) begin
      mem[START[7:0] + 8'(1 + 2*i)] = VEC[i][39:24];
      mem[START[7:0] + 8'(2 + 2*i)] = OUT5;
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cyc_state == 0, "R9 reset state", cyc_state, 0);
    chk(!mem_rd && !mem_wr && !dev_rd && !dev_wr, "R9 reset strobes",
        {mem_rd, mem_wr, dev_rd, dev_wr}, 0);
    rst_n = 1;

    repeat (20) @(negedge clk);
    chk(cyc_state == 0, "R10 halt holds step 0", cyc_state, 0);
    chk(rd_n == 0 && wr_n == 0, "R10 no access while halted", rd_n + wr_n, 0);

    step(cyc, fa, drd, dwr, ddin, ddout);
    chk(fa == START, "R9 first fetch at START_ADDR", fa, START);
    chk(last_out == 16'h0000, "R9 accumulator cleared", last_out, 0);
    chk(cyc == 6 && ddout == 1, "R7 output cycles/strobe", cyc, 6);
    pc_exp = START + 12'd1;

    for (int i = 0; i < NV; i++) begin
      op = VEC[i][39:36];
      exp_rd = (op == 4'h1 || op == 4'h5) ? 2 : 1;
      step(cyc, fa, drd, dwr, ddin, ddout);
      chk(fa == pc_exp, "R2 fetch address", fa, pc_exp);
      chk(cyc == int'(VEC[i][7:0]), "R3/R4/R5/R6/R8 cycle count", cyc, VEC[i][7:0]);
      chk(drd == exp_rd && dwr == (op == 4'h2 ? 1 : 0), "R5/R8 memory accesses",
          drd * 16 + dwr, exp_rd * 16 + (op == 4'h2 ? 1 : 0));
      chk(ddin == (op == 4'h3 ? 1 : 0) && ddout == 0, "R6/R8 device strobes",
          ddin * 16 + ddout, (op == 4'h3 ? 16 : 0));
      step(cyc, fa, drd, dwr, ddin, ddout);
      chk(fa == pc_exp + 12'd1, "R2 consecutive fetch", fa, pc_exp + 12'd1);
      chk(last_out == VEC[i][23:8], "R3/R4/R5/R6/R7/R8 accumulator", last_out, VEC[i][23:8]);
      chk(last_dev == 4'd5, "R1 device number field", last_dev, 5);
      if (op == 4'h2)
        chk(mem[8'h90] == 16'h2143, "R5 stored word", mem[8'h90], 16'h2143);
      pc_exp = pc_exp + 12'd2;
    end
    chk(last_out == 16'hA005, "R4 wrap add", last_out, 16'hA005);

    @(negedge clk);
    halt = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    halt = 1;
    @(negedge clk);
    chk(cyc_state == 0 && !mem_rd && !mem_wr, "R9 mid-run reset", cyc_state, 0);
    rst_n = 1;
    step(cyc, fa, drd, dwr, ddin, ddout);
    chk(fa == START, "R9 restart address", fa, START);
    chk(last_out == 16'h0000, "R9 accumulator cleared again", last_out, 0);

    finish_run();
  end
endmodule